// File: doc/BRIEF.md
# Bus Cycle Exception Controller

This block sits beside an asynchronous processor bus and decides how each bus cycle ends when it does not end normally. Once the address strobe is seen, a timer runs. Either bit of the two-bit transfer-size acknowledge, or the vector acknowledge, stops it and marks a normal end. If no acknowledge arrives within `TIMEOUT_CYCLES` clocks, the block raises the bus fault line. A retry request raises bus fault and stop together, which asks the processor to run the failed cycle again. A debug single-step input raises stop by itself.

All bus inputs pass through a `SYNC_STAGES`-deep synchronizer. Every output comes from a register clocked on the rising edge. Signals that assert together therefore change on the same edge. A two-bit status output keeps the outcome of the most recent terminated cycle until the next one ends.

Top module: `bus_excp_ctrl`

## Requirements
- R1: While rst_ni is low, bus_fault_o and stop_o are 0 and status_o is 0 (no cycle ended yet).
- R2: An acknowledge on either bit of size_ack_i or on vec_ack_i, seen while strobe_i is high, ends the cycle normally. bus_fault_o stays 0 and status_o becomes 1 on the (SYNC_STAGES+1)th rising edge after the acknowledge changes.
- R3: If strobe_i stays high with no acknowledge and no retry, bus_fault_o rises with stop_o low. This happens TIMEOUT_CYCLES+SYNC_STAGES+1 rising edges after strobe_i rose, and status_o becomes 2 on that edge.
- R4: A retry_i seen during an active cycle without an acknowledge raises bus_fault_o and stop_o on the same edge, and status_o becomes 3. A retry seen together with a timeout counts as a retry.
- R5: After a fault or retry, bus_fault_o and stop_o stay as they are while strobe_i is high. Both go low on the (SYNC_STAGES+1)th edge after strobe_i falls, and status_o is kept.
- R6: If an acknowledge reaches the controller on the same clock as the timeout, the acknowledge wins: bus_fault_o stays 0 and status_o becomes 1.
- R7: While no fault is signalled, stop_o follows step_i with SYNC_STAGES+1 edges of delay, and bus_fault_o stays 0.
- R8: If strobe_i falls before any acknowledge or timeout, there is no fault. The timer clears, so the next cycle again gets the full TIMEOUT_CYCLES window.
- R9: An acknowledge while strobe_i is low changes no output, and status_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Processor clock; all outputs change on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Address strobe, high while a bus cycle is active |
| size_ack_i | input | 2 | Transfer-size acknowledge lines; either bit ends the cycle |
| vec_ack_i | input | 1 | Vector acknowledge; ends the cycle like size_ack_i |
| retry_i | input | 1 | Request to end the current cycle as a retry |
| step_i | input | 1 | Debug single-step request, drives stop alone |
| bus_fault_o | output | 1 | Bus error to the processor |
| stop_o | output | 1 | Halt to the processor; with bus_fault_o it means retry |
| status_o | output | 2 | Last outcome: 0 none, 1 normal, 2 timeout, 3 retry |

## Verification
A timer that is off by one shows up as bus_fault_o rising one edge early or late. The bench checks the edge before the fault and the fault edge itself. A phase register stuck in the hold state shows up three edges after the strobe falls, when bus_fault_o fails to release. Wrong arbitration shows up on the tie edge as a fault instead of status 1, and on the retry edge as stop_o and bus_fault_o rising on different edges. A timer that is not cleared after an abandoned cycle gives a fault earlier than TIMEOUT_CYCLES in the next cycle.

// File: rtl/bex_pkg.sv
package bex_pkg;
  typedef enum logic [1:0] {
    BX_NONE    = 2'd0,
    BX_OK      = 2'd1,
    BX_TIMEOUT = 2'd2,
    BX_RETRY   = 2'd3
  } bx_status_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_HOLD   = 2'd2
  } bx_phase_e;
endpackage

// File: rtl/bex_sync.sv
module bex_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bex_timer.sv
module bex_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;

  assign expire_o = run_i && (cnt_q == LAST);

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_cnt_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/bex_term_fsm.sv
module bex_term_fsm
  import bex_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       as_i,
  input  logic       ack_i,
  input  logic       retry_i,
  input  logic       step_i,
  input  logic       expire_i,
  output logic       run_o,
  output logic       fault_o,
  output logic       stop_o,
  output logic [1:0] status_o
);
  bx_phase_e  phase_q, phase_d;
  bx_status_e status_q, status_d;
  logic fault_q, fault_d, pair_q, pair_d, stop_q, stop_d;

  // priority: acknowledge > retry > timeout
  always_comb begin
    phase_d  = phase_q;
    status_d = status_q;
    fault_d  = fault_q;
    pair_d   = pair_q;
    unique case (phase_q)
      PH_IDLE: if (as_i) phase_d = PH_ACTIVE;
      PH_ACTIVE: begin
        if (!as_i) begin
          phase_d = PH_IDLE;
        end else if (ack_i) begin
          phase_d  = PH_HOLD;
          status_d = BX_OK;
        end else if (retry_i) begin
          phase_d  = PH_HOLD;
          status_d = BX_RETRY;
          fault_d  = 1'b1;
          pair_d   = 1'b1;
        end else if (expire_i) begin
          phase_d  = PH_HOLD;
          status_d = BX_TIMEOUT;
          fault_d  = 1'b1;
          pair_d   = 1'b0;
        end
      end
      PH_HOLD: if (!as_i) begin
        phase_d = PH_IDLE;
        fault_d = 1'b0;
        pair_d  = 1'b0;
      end
      default: phase_d = PH_IDLE;
    endcase
    // while a fault is signalled, stop carries the retry flag only
    stop_d = fault_d ? pair_d : step_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      status_q <= BX_NONE;
      fault_q  <= 1'b0;
      pair_q   <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      status_q <= status_d;
      fault_q  <= fault_d;
      pair_q   <= pair_d;
      stop_q   <= stop_d;
    end

  assign run_o    = (phase_q == PH_ACTIVE);
  assign fault_o  = fault_q;
  assign stop_o   = stop_q;
  assign status_o = status_q;

  assert_fault_from_active_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(phase_q) == PH_ACTIVE);
  assert_pair_is_retry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && stop_q) |-> status_q == BX_RETRY);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && as_i) |=> fault_q && $stable(stop_q));
  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !as_i) |=> !fault_q);
  assert_ack_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ACTIVE && as_i && ack_i) |=> !fault_q && status_q == BX_OK);
  assert_step_alone_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stop_q) && !fault_q) |-> $past(step_i));
endmodule

// File: rtl/bus_excp_ctrl.sv
module bus_excp_ctrl #(
  parameter int TIMEOUT_CYCLES = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic [1:0] size_ack_i,
  input  logic       vec_ack_i,
  input  logic       retry_i,
  input  logic       step_i,
  output logic       bus_fault_o,
  output logic       stop_o,
  output logic [1:0] status_o
);
  localparam int NIN = 6;

  logic [NIN-1:0] raw, syn;
  logic run, expire, ack_s;

  assign raw = {step_i, retry_i, vec_ack_i, size_ack_i, strobe_i};

  bex_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign ack_s = |syn[3:1];

  bex_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .expire_o(expire)
  );

  bex_term_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .as_i    (syn[0]),
    .ack_i   (ack_s),
    .retry_i (syn[4]),
    .step_i  (syn[5]),
    .expire_i(expire),
    .run_o   (run),
    .fault_o (bus_fault_o),
    .stop_o  (stop_o),
    .status_o(status_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !bus_fault_o && !stop_o && status_o == 2'd0);
  assert_idle_ack_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!syn[0] && !bus_fault_o) |=> $stable(status_o));
endmodule

// File: tb/bus_excp_ctrl_test.sv
`timescale 1ns/1ps
module bus_excp_ctrl_test;
  localparam int L   = 8;
  localparam int SYN = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic strobe = 1'b0, vec_ack = 1'b0, retry = 1'b0, step = 1'b0;
  logic [1:0] size_ack = 2'b00;
  logic fault, stop;
  logic [1:0] status;

  int cyc = 0, n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    bit         f;
    bit         s;
    logic [1:0] st;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t it;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_excp_ctrl #(.TIMEOUT_CYCLES(L), .SYNC_STAGES(SYN)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe), .size_ack_i(size_ack),
    .vec_ack_i(vec_ack), .retry_i(retry), .step_i(step),
    .bus_fault_o(fault), .stop_o(stop), .status_o(status)
  );

  task automatic push(input int at, input bit f, input bit s, input logic [1:0] st,
                      input string tag);
    exp_t e;
    e.at = at; e.f = f; e.s = s; e.st = st; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic at_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: compare outputs against scoreboard entries due this cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
      it = exp_q.pop_front();
      n_vec++;
      if (it.at < cyc || fault !== it.f || stop !== it.s || status !== it.st) begin
        n_bad++;
        $display("FAIL %s cyc %0d: fault/stop/status = %b/%b/%0d, expected %b/%b/%0d",
                 it.tag, it.at, fault, stop, status, it.f, it.s, it.st);
      end
    end
  end

  initial begin
    int t;
    push(2, 0, 0, 2'd0, "R1");
    at_cyc(3); rst_ni = 1'b1;

    // normal end via size acknowledge
    t = 10; at_cyc(t); strobe = 1'b1;
    at_cyc(t+5); size_ack = 2'b01;
    push(t+7, 0, 0, 2'd0, "R2");
    push(t+8, 0, 0, 2'd1, "R2");
    push(t+12, 0, 0, 2'd1, "R2");
    at_cyc(t+20); strobe = 1'b0; size_ack = 2'b00;
    push(t+23, 0, 0, 2'd1, "R2");

    // timeout
    t = 40; at_cyc(t); strobe = 1'b1;
    push(t+2+L, 0, 0, 2'd1, "R3");
    push(t+3+L, 1, 0, 2'd2, "R3");
    push(t+7+L, 1, 0, 2'd2, "R5");
    at_cyc(t+L+10); strobe = 1'b0;
    push(t+L+12, 1, 0, 2'd2, "R5");
    push(t+L+13, 0, 0, 2'd2, "R5");

    // normal end via vector acknowledge
    t = 70; at_cyc(t); strobe = 1'b1;
    at_cyc(t+2); vec_ack = 1'b1;
    push(t+5, 0, 0, 2'd1, "R2");
    at_cyc(t+8); strobe = 1'b0; vec_ack = 1'b0;
    push(t+11, 0, 0, 2'd1, "R2");

    // retry
    t = 90; at_cyc(t); strobe = 1'b1;
    at_cyc(t+2); retry = 1'b1;
    push(t+4, 0, 0, 2'd1, "R4");
    push(t+5, 1, 1, 2'd3, "R4");
    at_cyc(t+10); strobe = 1'b0; retry = 1'b0;
    push(t+12, 1, 1, 2'd3, "R5");
    push(t+13, 0, 0, 2'd3, "R5");

    // acknowledge on the timeout clock
    t = 110; at_cyc(t); strobe = 1'b1;
    at_cyc(t+L); size_ack = 2'b10;
    push(t+L+2, 0, 0, 2'd3, "R6");
    push(t+L+3, 0, 0, 2'd1, "R6");
    push(t+L+6, 0, 0, 2'd1, "R6");
    at_cyc(t+L+8); strobe = 1'b0; size_ack = 2'b00;

    // single step
    t = 140; at_cyc(t); step = 1'b1;
    push(t+2, 0, 0, 2'd1, "R7");
    push(t+3, 0, 1, 2'd1, "R7");
    at_cyc(t+6); step = 1'b0;
    push(t+9, 0, 0, 2'd1, "R7");

    // acknowledge with no cycle active
    t = 160; at_cyc(t); size_ack = 2'b11; vec_ack = 1'b1;
    push(t+3, 0, 0, 2'd1, "R9");
    push(t+6, 0, 0, 2'd1, "R9");
    at_cyc(t+8); size_ack = 2'b00; vec_ack = 1'b0;

    // abandoned cycle, then full window again
    t = 180; at_cyc(t); strobe = 1'b1;
    at_cyc(t+3); strobe = 1'b0;
    push(t+3+L+3, 0, 0, 2'd1, "R8");
    at_cyc(t+12); strobe = 1'b1;
    push(t+12+2+L, 0, 0, 2'd1, "R8");
    push(t+12+3+L, 1, 0, 2'd2, "R8");
    at_cyc(t+30); strobe = 1'b0;
    push(t+33, 0, 0, 2'd2, "R5");

    at_cyc(t+40);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: cycles %0d, expected end before 5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule